// File: doc/BRIEF.md
# Load-Hoisting Alias Guard

This block lets a scheduler move a load ahead of an older store. The hoisted load is issued as a protecting load: it writes its start address and access size into a slot that the load itself names, in a small table of guarded byte ranges. A later store that may hit one of those ranges is issued as a checked store. The checked store carries a mask that selects the slots it must be compared against. If the bytes the store writes overlap any selected guarded range, the block raises an alias trap in the same cycle. That is early enough for the store to be held back before it is buffered, so a runtime can recover.

A guarded range stays in the table across any number of checked stores, including stores that trap. This lets the value from the protected load be reused instead of loaded again. A single clear pulse, issued when a group of work commits or rolls back, empties the whole table. Plain stores never enter the block, so they are never compared.

Top module: `alias_guard`

## Requirements
- R1: After reset no slot is valid: a checked store to any address with every slot selected gives `trap_o` = 0 and `trap_slot_o` = 0.
- R2: A protect request stores its address and size code in the slot given by `prot_slot_i`. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A later protect to the same slot replaces the earlier range completely.
- R3: A checked store traps when its byte range [addr, addr+size) overlaps a selected valid range [base, base+size). A store that only touches either edge of that range does not trap.
- R4: A slot whose bit in `chk_mask_i` is 0 never causes a trap. Bit i of the mask selects slot i.
- R5: When several selected slots overlap the store, `trap_slot_o` reports the lowest-numbered of them.
- R6: With `chk_valid_i` low, `trap_o` is 0 whatever the address, size and mask inputs hold.
- R7: A guarded range stays valid across checked stores, including stores that trap, until a clear.
- R8: A clear pulse invalidates every slot from the next cycle on. A protect issued in the same cycle as a clear is discarded.
- R9: The trap is combinational from the checked-store request and sees the table as it stood before the current edge. A protect issued in the same cycle as a check takes part only in later checks.
- R10: `trap_slot_o` is 0 whenever `trap_o` is 0.
- R11: Range ends are computed one bit wider than the address, so a range that reaches the top of the address space does not wrap around to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_valid_i | input | 1 | Protecting load request |
| prot_slot_i | input | $clog2(SLOTS) | Slot to write |
| prot_addr_i | input | ADDR_W | Start byte address of the load |
| prot_size_i | input | 2 | Size code of the load (0:1, 1:2, 2:4, 3:8 bytes) |
| chk_valid_i | input | 1 | Checked store request |
| chk_addr_i | input | ADDR_W | Start byte address of the store |
| chk_size_i | input | 2 | Size code of the store |
| chk_mask_i | input | SLOTS | Slots to compare against the store |
| clear_i | input | 1 | Commit or rollback: drop all ranges |
| trap_o | output | 1 | Alias trap, same cycle as the checked store |
| trap_slot_o | output | $clog2(SLOTS) | Lowest overlapping selected slot |

## Verification
The bench builds the block with its defaults: 8 slots and 32-bit addresses. With 8 slots, two slots can guard the same range while a third holds an unrelated one, so masking and lowest-index selection can be checked against each other. With 32-bit addresses, a range that ends exactly at the top of the address space can be guarded, and a store at address 0 shows that the range end does not wrap.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;

    typedef logic [1:0] size_code_t;

    // Size code to byte count: 1, 2, 4 or 8.
    function automatic logic [3:0] code_to_bytes(input size_code_t code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/alias_guard_table.sv
module alias_guard_table
    import alias_guard_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          prot_valid_i,
    input  logic [SLOT_W-1:0]             prot_slot_i,
    input  logic [ADDR_W-1:0]             prot_addr_i,
    input  size_code_t                    prot_size_i,
    input  logic                          clear_i,
    output logic [SLOTS-1:0]              valid_o,
    output logic [SLOTS-1:0][ADDR_W-1:0]  base_o,
    output logic [SLOTS-1:0][1:0]         code_o
);

    typedef struct packed {
        logic [SLOTS-1:0]             valid;
        logic [SLOTS-1:0][ADDR_W-1:0] base;
        logic [SLOTS-1:0][1:0]        code;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (clear_i) begin
            // Commit or rollback wins over a protect in the same cycle.
            tbl_d.valid = '0;
        end else if (prot_valid_i) begin
            tbl_d.valid[prot_slot_i] = 1'b1;
            tbl_d.base[prot_slot_i]  = prot_addr_i;
            tbl_d.code[prot_slot_i]  = prot_size_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign valid_o = tbl_q.valid;
    assign base_o  = tbl_q.base;
    assign code_o  = tbl_q.code;

    assert_clear_empties_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (valid_o == '0));

    assert_protect_records_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (prot_valid_i && !clear_i) |=>
            (valid_o[$past(prot_slot_i)] &&
             base_o[$past(prot_slot_i)] == $past(prot_addr_i) &&
             code_o[$past(prot_slot_i)] == $past(prot_size_i)));

    assert_slots_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_valid_i && !clear_i) |=> $stable(valid_o));

endmodule

// File: rtl/alias_guard_overlap.sv
module alias_guard_overlap
    import alias_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] a_base_i,
    input  size_code_t        a_code_i,
    input  logic [ADDR_W-1:0] b_base_i,
    input  size_code_t        b_code_i,
    output logic              hit_o
);

    localparam int PAD_W = ADDR_W - 3;

    // One extra bit so that ranges near the top of memory do not wrap.
    logic [ADDR_W:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo  = {1'b0, a_base_i};
        b_lo  = {1'b0, b_base_i};
        a_hi  = a_lo + {{PAD_W{1'b0}}, code_to_bytes(a_code_i)};
        b_hi  = b_lo + {{PAD_W{1'b0}}, code_to_bytes(b_code_i)};
        hit_o = (a_lo < b_hi) && (b_lo < a_hi);
    end

endmodule

// File: rtl/alias_guard_pick.sv
module alias_guard_pick #(
    parameter int SLOTS = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0]  req_i,
    output logic              any_o,
    output logic [SLOT_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = SLOT_W'(i);
            end
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/alias_guard.sv
module alias_guard
    import alias_guard_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prot_valid_i,
    input  logic [SLOT_W-1:0] prot_slot_i,
    input  logic [ADDR_W-1:0] prot_addr_i,
    input  logic [1:0]        prot_size_i,
    input  logic              chk_valid_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    input  logic [1:0]        chk_size_i,
    input  logic [SLOTS-1:0]  chk_mask_i,
    input  logic              clear_i,
    output logic              trap_o,
    output logic [SLOT_W-1:0] trap_slot_o
);

    logic [SLOTS-1:0]             slot_valid;
    logic [SLOTS-1:0][ADDR_W-1:0] slot_base;
    logic [SLOTS-1:0][1:0]        slot_code;
    logic [SLOTS-1:0]             range_hit;
    logic [SLOTS-1:0]             armed_hit;
    logic                         any_hit;
    logic [SLOT_W-1:0]            first_hit;

    alias_guard_table #(
        .SLOTS (SLOTS),
        .ADDR_W(ADDR_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .prot_valid_i(prot_valid_i),
        .prot_slot_i (prot_slot_i),
        .prot_addr_i (prot_addr_i),
        .prot_size_i (prot_size_i),
        .clear_i     (clear_i),
        .valid_o     (slot_valid),
        .base_o      (slot_base),
        .code_o      (slot_code)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        alias_guard_overlap #(
            .ADDR_W(ADDR_W)
        ) u_overlap (
            .a_base_i(slot_base[g]),
            .a_code_i(slot_code[g]),
            .b_base_i(chk_addr_i),
            .b_code_i(chk_size_i),
            .hit_o   (range_hit[g])
        );
    end

    always_comb begin
        armed_hit = {SLOTS{chk_valid_i}} & chk_mask_i & slot_valid & range_hit;
    end

    alias_guard_pick #(
        .SLOTS(SLOTS)
    ) u_pick (
        .req_i(armed_hit),
        .any_o(any_hit),
        .idx_o(first_hit)
    );

    assign trap_o      = any_hit;
    assign trap_slot_o = any_hit ? first_hit : '0;

    assert_trap_needs_check_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> chk_valid_i);

    assert_trap_slot_selected_R4 : assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (chk_mask_i[trap_slot_o] && slot_valid[trap_slot_o]));

    assert_lowest_first_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ((armed_hit & ((SLOTS'(1) << trap_slot_o) - SLOTS'(1))) == '0));

    assert_quiet_index_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> (trap_slot_o == '0));

endmodule

// File: tb/alias_guard_bench.sv
`timescale 1ns/1ps
module alias_guard_bench;

    localparam int SLOTS  = 8;
    localparam int ADDR_W = 32;
    localparam int SLOT_W = $clog2(SLOTS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              prot_valid_i = 1'b0;
    logic [SLOT_W-1:0] prot_slot_i = '0;
    logic [ADDR_W-1:0] prot_addr_i = '0;
    logic [1:0]        prot_size_i = '0;
    logic              chk_valid_i = 1'b0;
    logic [ADDR_W-1:0] chk_addr_i = '0;
    logic [1:0]        chk_size_i = '0;
    logic [SLOTS-1:0]  chk_mask_i = '0;
    logic              clear_i = 1'b0;
    logic              trap_o;
    logic [SLOT_W-1:0] trap_slot_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    alias_guard #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_alias_guard (
        .clk(clk), .rst_n(rst_n),
        .prot_valid_i(prot_valid_i), .prot_slot_i(prot_slot_i),
        .prot_addr_i(prot_addr_i), .prot_size_i(prot_size_i),
        .chk_valid_i(chk_valid_i), .chk_addr_i(chk_addr_i),
        .chk_size_i(chk_size_i), .chk_mask_i(chk_mask_i),
        .clear_i(clear_i), .trap_o(trap_o), .trap_slot_o(trap_slot_o)
    );

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input bit exp_t, input logic [SLOT_W-1:0] exp_s, input string req);
        checks++;
        if (trap_o !== exp_t || trap_slot_o !== exp_s) begin
            errors++;
            $display("FAIL %s: trap=%0b slot=%0d expected trap=%0b slot=%0d",
                     req, trap_o, trap_slot_o, exp_t, exp_s);
        end
    endtask

    task automatic protect(input int slot, input logic [ADDR_W-1:0] addr, input logic [1:0] sz);
        prot_valid_i = 1'b1;
        prot_slot_i  = SLOT_W'(slot);
        prot_addr_i  = addr;
        prot_size_i  = sz;
        next_cycle();
        prot_valid_i = 1'b0;
    endtask

    task automatic probe(input logic [ADDR_W-1:0] addr, input logic [1:0] sz,
                         input logic [SLOTS-1:0] mask, input bit exp_t,
                         input int exp_s, input string req);
        chk_valid_i = 1'b1;
        chk_addr_i  = addr;
        chk_size_i  = sz;
        chk_mask_i  = mask;
        #1;
        expect_out(exp_t, SLOT_W'(exp_s), req);
        next_cycle();
        chk_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        probe(32'h0000_0100, 2'd3, 8'hFF, 0, 0, "R1");
        probe(32'h0000_0000, 2'd0, 8'hFF, 0, 0, "R1");
    endtask

    task automatic t_overlap_edges();
        protect(3, 32'h0000_0100, 2'd2);            // [0x100,0x104)
        probe(32'h0000_0103, 2'd0, 8'hFF, 1, 3, "R3");
        probe(32'h0000_0104, 2'd0, 8'hFF, 0, 0, "R3");
        probe(32'h0000_00FE, 2'd1, 8'hFF, 0, 0, "R3");
        probe(32'h0000_00FF, 2'd1, 8'hFF, 1, 3, "R3");
    endtask

    task automatic t_sizes();
        protect(0, 32'h0000_0200, 2'd3);            // 8 bytes
        probe(32'h0000_0207, 2'd0, 8'hFF, 1, 0, "R2");
        probe(32'h0000_0208, 2'd0, 8'hFF, 0, 0, "R2");
        protect(1, 32'h0000_0300, 2'd0);            // 1 byte
        probe(32'h0000_0300, 2'd0, 8'hFF, 1, 1, "R2");
        probe(32'h0000_0301, 2'd0, 8'hFF, 0, 0, "R2");
        protect(1, 32'h0000_0400, 2'd1);            // replaces slot 1
        probe(32'h0000_0300, 2'd0, 8'hFF, 0, 0, "R2");
        probe(32'h0000_0401, 2'd0, 8'hFF, 1, 1, "R2");
    endtask

    task automatic t_mask();
        probe(32'h0000_0100, 2'd0, 8'hF7, 0, 0, "R4");
        probe(32'h0000_0100, 2'd0, 8'h08, 1, 3, "R4");
    endtask

    task automatic t_priority();
        protect(5, 32'h0000_0100, 2'd3);
        probe(32'h0000_0100, 2'd0, 8'hFF, 1, 3, "R5");
        probe(32'h0000_0100, 2'd0, 8'hF7, 1, 5, "R5");
    endtask

    task automatic t_no_check();
        chk_addr_i = 32'h0000_0100;
        chk_size_i = 2'd3;
        chk_mask_i = 8'hFF;
        chk_valid_i = 1'b0;
        #1;
        expect_out(0, 0, "R6");
        next_cycle();
    endtask

    task automatic t_persist();
        probe(32'h0000_0101, 2'd0, 8'hFF, 1, 3, "R7");
        probe(32'h0000_0500, 2'd0, 8'hFF, 0, 0, "R7");
        probe(32'h0000_0102, 2'd0, 8'h08, 1, 3, "R7");
    endtask

    task automatic t_same_cycle();
        prot_valid_i = 1'b1;
        prot_slot_i  = SLOT_W'(6);
        prot_addr_i  = 32'h0000_0800;
        prot_size_i  = 2'd2;
        chk_valid_i  = 1'b1;
        chk_addr_i   = 32'h0000_0800;
        chk_size_i   = 2'd0;
        chk_mask_i   = 8'hFF;
        #1;
        expect_out(0, 0, "R9");
        next_cycle();
        prot_valid_i = 1'b0;
        chk_valid_i  = 1'b0;
        probe(32'h0000_0802, 2'd0, 8'hFF, 1, 6, "R9");
    endtask

    task automatic t_top_of_memory();
        protect(2, 32'hFFFF_FFF8, 2'd3);
        probe(32'hFFFF_FFFC, 2'd2, 8'h04, 1, 2, "R11");
        probe(32'h0000_0000, 2'd3, 8'h04, 0, 0, "R11");
    endtask

    task automatic t_clear();
        clear_i      = 1'b1;
        prot_valid_i = 1'b1;
        prot_slot_i  = SLOT_W'(7);
        prot_addr_i  = 32'h0000_0900;
        prot_size_i  = 2'd2;
        next_cycle();
        clear_i      = 1'b0;
        prot_valid_i = 1'b0;
        probe(32'h0000_0100, 2'd3, 8'hFF, 0, 0, "R8");
        probe(32'h0000_0900, 2'd0, 8'hFF, 0, 0, "R8");
        probe(32'hFFFF_FFFC, 2'd2, 8'hFF, 0, 0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_overlap_edges();
        t_sizes();
        t_mask();
        t_priority();
        t_no_check();
        t_persist();
        t_same_cycle();
        t_top_of_memory();
        t_clear();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule